// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block decides whether a phase-locked loop has settled. It watches two single-cycle pulse streams, one marking each edge of the divided reference and one marking each edge of the divided feedback. Both are already synchronized to a fast system clock. For every phase-detector cycle it pairs a reference edge with its feedback partner and measures how many system-clock ticks separate them. That tick count is the phase error.

A lock flag goes high once a run of consecutive measurements falls inside an acquire window. Two acquire windows exist, tight and loose, and an input picks one. Once the flag is set, only a much larger error clears it, so the flag has hysteresis. A power-down input clears the whole detector. Every threshold and the run length are parameters in ticks or cycles. The defaults are 3, 10 and 25 ticks, with a run of 5 cycles.

Top module: `pll_lock_detect`

## Requirements
- R1: After reset, lock_o is 0. It stays 0 until a full run of acquire-window measurements has been seen.
- R2: Phase error is the tick distance from the first edge of a pair to its partner, whichever input leads. A partner arriving d clock cycles after the first edge gives error d. Two edges in the same cycle give error 0.
- R3: With prec_sel_i = 0, five consecutive cycles with error strictly below LOOSE_TICKS (10) set lock_o. lock_o rises one clock after the fifth partner edge is sampled. Four such cycles are not enough, and an error equal to 10 does not count.
- R4: With prec_sel_i = 1, the acquire test uses TIGHT_TICKS (3), still over five consecutive cycles. An error of 5 does not count.
- R5: Before lock, any measurement at or above the active acquire threshold clears the consecutive count to zero.
- R6: Once lock_o is 1, it stays 1 for any error up to and including RELEASE_TICKS (25). It drops on the first cycle with an error strictly above 25. A partner 26 or more ticks late saturates the count at 26.
- R7: A second edge on the same input before the partner arrives is an out-of-window cycle. Before lock it clears the count, and after lock it drops lock_o. The new edge then opens a fresh pair.
- R8: While pwr_dn_i is 1, lock_o is 0 from the next clock on, the count and any open pair are cleared, and incoming pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; one tick of phase error |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_dn_i | input | 1 | Power-down, synchronous clear of the detector |
| ref_pulse_i | input | 1 | One-cycle pulse per divided reference edge |
| fb_pulse_i | input | 1 | One-cycle pulse per divided feedback edge |
| prec_sel_i | input | 1 | 0 selects the loose acquire window, 1 the tight one |
| lock_o | output | 1 | Active-high lock flag |

## Verification
The assertions check on every cycle that:
- a locked flag holds through any measurement not past the release threshold;
- a release-class measurement or power-down clears it on the next edge;
- an out-of-window measurement before lock zeroes the run;
- a rising flag is always preceded by an acquire-window measurement;
- the acquire and release decisions never coincide.

Only the bench scenarios can show the rest:
- the tick arithmetic of the pairing, including feedback-first pairs and same-cycle edges;
- the strict boundaries at 10, 3, 25 and 26 ticks;
- the exact run length of five;
- the effect of duplicate edges.

// File: rtl/pld_pkg.sv
package pld_pkg;
  typedef enum logic [1:0] {
    PS_IDLE     = 2'd0,
    PS_WAIT_FB  = 2'd1,
    PS_WAIT_REF = 2'd2
  } pair_st_e;
endpackage

// File: rtl/pld_pair_meter.sv
module pld_pair_meter
  import pld_pkg::*;
#(
  parameter int SAT   = 26,
  parameter int ERR_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ref_i,
  input  logic             fb_i,
  output logic             valid_o,
  output logic             miss_o,
  output logic [ERR_W-1:0] err_o
);
  localparam logic [ERR_W-1:0] SatV = ERR_W'(SAT);
  localparam logic [ERR_W-1:0] OneV = ERR_W'(1);

  pair_st_e         st_q;
  logic [ERR_W-1:0] cnt_q;
  logic             partner, same;

  always_comb begin
    partner = (st_q == PS_WAIT_FB) ? fb_i  : ref_i;
    same    = (st_q == PS_WAIT_FB) ? ref_i : fb_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= PS_IDLE;
      cnt_q   <= '0;
      valid_o <= 1'b0;
      miss_o  <= 1'b0;
      err_o   <= '0;
    end else if (clr_i) begin
      st_q    <= PS_IDLE;
      cnt_q   <= '0;
      valid_o <= 1'b0;
      miss_o  <= 1'b0;
      err_o   <= '0;
    end else begin
      valid_o <= 1'b0;
      miss_o  <= 1'b0;
      if (st_q == PS_IDLE) begin
        if (ref_i && fb_i) begin
          valid_o <= 1'b1;
          err_o   <= '0;
        end else if (ref_i) begin
          st_q  <= PS_WAIT_FB;
          cnt_q <= OneV;
        end else if (fb_i) begin
          st_q  <= PS_WAIT_REF;
          cnt_q <= OneV;
        end
      end else begin
        if (partner) begin
          valid_o <= 1'b1;
          err_o   <= cnt_q;
          // a coincident leading edge opens the next pair in the same direction
          if (same) cnt_q <= OneV;
          else      st_q  <= PS_IDLE;
        end else if (same) begin
          valid_o <= 1'b1;
          miss_o  <= 1'b1;
          err_o   <= SatV;
          cnt_q   <= OneV;
        end else if (cnt_q != SatV) begin
          cnt_q <= cnt_q + OneV;
        end
      end
    end
  end

  // R6
  err_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (err_o <= SatV));

  // R7
  miss_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (valid_o && err_o == SatV));

  // R8
  meter_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !valid_o);
endmodule

// File: rtl/pld_window_cmp.sv
module pld_window_cmp #(
  parameter int TIGHT_TICKS   = 3,
  parameter int LOOSE_TICKS   = 10,
  parameter int RELEASE_TICKS = 25,
  parameter int ERR_W         = 5
) (
  input  logic             valid_i,
  input  logic             miss_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic             prec_sel_i,
  output logic             acq_ok_o,
  output logic             rel_hit_o
);
  localparam logic [ERR_W-1:0] TightV = ERR_W'(TIGHT_TICKS);
  localparam logic [ERR_W-1:0] LooseV = ERR_W'(LOOSE_TICKS);
  localparam logic [ERR_W-1:0] RelV   = ERR_W'(RELEASE_TICKS);

  logic [ERR_W-1:0] acq_thr;

  always_comb begin
    acq_thr   = prec_sel_i ? TightV : LooseV;
    acq_ok_o  = valid_i && !miss_i && (err_i < acq_thr);
    rel_hit_o = valid_i && (miss_i || (err_i > RelV));
  end

  // R6
  always_comb begin
    window_excl_chk: assert (!(acq_ok_o && rel_hit_o));
  end
endmodule

// File: rtl/pld_lock_fsm.sv
module pld_lock_fsm #(
  parameter int LOCK_CYCLES = 5,
  parameter int RUN_W       = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic valid_i,
  input  logic acq_ok_i,
  input  logic rel_hit_i,
  output logic lock_o
);
  localparam logic [RUN_W-1:0] LastV = RUN_W'(LOCK_CYCLES - 1);

  logic             lock_q;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      run_q  <= '0;
    end else if (clr_i) begin
      lock_q <= 1'b0;
      run_q  <= '0;
    end else if (!lock_q) begin
      if (valid_i) begin
        if (!acq_ok_i) begin
          run_q <= '0;
        end else if (run_q == LastV) begin
          lock_q <= 1'b1;
          run_q  <= '0;
        end else begin
          run_q <= run_q + RUN_W'(1);
        end
      end
    end else if (rel_hit_i) begin
      lock_q <= 1'b0;
      run_q  <= '0;
    end
  end

  assign lock_o = lock_q;

  // R6
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !clr_i && !rel_hit_i) |=> lock_q);

  // R6
  lock_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && rel_hit_i) |=> !lock_q);

  // R8
  pd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!lock_q && run_q == '0));

  // R5
  run_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_q && valid_i && !acq_ok_i) |=> (run_q == '0 && !lock_q));

  // R3
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(valid_i && acq_ok_i && !clr_i));

  // R1
  run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= LastV);
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
  parameter int TIGHT_TICKS   = 3,
  parameter int LOOSE_TICKS   = 10,
  parameter int RELEASE_TICKS = 25,
  parameter int LOCK_CYCLES   = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_dn_i,
  input  logic ref_pulse_i,
  input  logic fb_pulse_i,
  input  logic prec_sel_i,
  output logic lock_o
);
  localparam int SAT   = RELEASE_TICKS + 1;
  localparam int ERR_W = $clog2(SAT + 1);
  localparam int RUN_W = $clog2(LOCK_CYCLES + 1);

  logic             meas_valid, meas_miss, acq_ok, rel_hit;
  logic [ERR_W-1:0] meas_err;

  pld_pair_meter #(
    .SAT   (SAT),
    .ERR_W (ERR_W)
  ) i_meter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (pwr_dn_i),
    .ref_i   (ref_pulse_i),
    .fb_i    (fb_pulse_i),
    .valid_o (meas_valid),
    .miss_o  (meas_miss),
    .err_o   (meas_err)
  );

  pld_window_cmp #(
    .TIGHT_TICKS   (TIGHT_TICKS),
    .LOOSE_TICKS   (LOOSE_TICKS),
    .RELEASE_TICKS (RELEASE_TICKS),
    .ERR_W         (ERR_W)
  ) i_window (
    .valid_i    (meas_valid),
    .miss_i     (meas_miss),
    .err_i      (meas_err),
    .prec_sel_i (prec_sel_i),
    .acq_ok_o   (acq_ok),
    .rel_hit_o  (rel_hit)
  );

  pld_lock_fsm #(
    .LOCK_CYCLES (LOCK_CYCLES),
    .RUN_W       (RUN_W)
  ) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (pwr_dn_i),
    .valid_i   (meas_valid),
    .acq_ok_i  (acq_ok),
    .rel_hit_i (rel_hit),
    .lock_o    (lock_o)
  );

  // R8
  top_pd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_i |=> !lock_o);
endmodule

// File: tb/test_pll_lock_detect.sv
module test_pll_lock_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_dn = 1'b0;
  logic ref_p = 1'b0;
  logic fb_p = 1'b0;
  logic prec = 1'b0;
  logic lock;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pll_lock_detect i_pll_lock_detect (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pwr_dn_i    (pwr_dn),
    .ref_pulse_i (ref_p),
    .fb_pulse_i  (fb_p),
    .prec_sel_i  (prec),
    .lock_o      (lock)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s lock_o actual %0b expected %0b", req, act, exp);
    end
  endtask

  // one phase-detector cycle: partner d cycles after the first edge
  task automatic pd_cycle(int d, bit ref_first);
    @(negedge clk);
    if (d == 0) begin
      ref_p = 1'b1;
      fb_p  = 1'b1;
      @(negedge clk);
      ref_p = 1'b0;
      fb_p  = 1'b0;
    end else begin
      if (ref_first) ref_p = 1'b1; else fb_p = 1'b1;
      @(negedge clk);
      ref_p = 1'b0;
      fb_p  = 1'b0;
      repeat (d - 1) @(negedge clk);
      if (ref_first) fb_p = 1'b1; else ref_p = 1'b1;
      @(negedge clk);
      ref_p = 1'b0;
      fb_p  = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic run(int n, int d, bit ref_first);
    for (int i = 0; i < n; i++) pd_cycle(d, ref_first);
  endtask

  // two reference edges 2 apart, then feedback 1 after the second
  task automatic dup_ref();
    @(negedge clk); ref_p = 1'b1;
    @(negedge clk); ref_p = 1'b0;
    @(negedge clk); ref_p = 1'b1;
    @(negedge clk); ref_p = 1'b0; fb_p = 1'b1;
    @(negedge clk); fb_p = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_dut();
    @(negedge clk); pwr_dn = 1'b1;
    @(negedge clk); pwr_dn = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 reset", lock, 1'b0);
  endtask

  task automatic t_loose();
    clear_dut(); prec = 1'b0;
    run(4, 9, 1'b1);
    check("R3 four cycles", lock, 1'b0);
    run(1, 9, 1'b1);
    check("R3 fifth cycle", lock, 1'b1);
    clear_dut();
    run(6, 10, 1'b1);
    check("R3 error equal 10", lock, 1'b0);
    clear_dut();
    run(5, 9, 1'b0);
    check("R2 feedback first", lock, 1'b1);
  endtask

  task automatic t_tight();
    clear_dut(); prec = 1'b1;
    run(6, 5, 1'b1);
    check("R4 error 5 tight", lock, 1'b0);
    clear_dut();
    run(5, 2, 1'b1);
    check("R4 error 2 tight", lock, 1'b1);
    clear_dut();
    run(5, 0, 1'b1);
    check("R2 same-cycle edges", lock, 1'b1);
    prec = 1'b0;
  endtask

  task automatic t_run_clear();
    clear_dut();
    run(4, 1, 1'b1);
    run(1, 12, 1'b1);
    run(4, 1, 1'b1);
    check("R5 bad cycle clears run", lock, 1'b0);
    run(1, 1, 1'b1);
    check("R5 fresh run completes", lock, 1'b1);
  endtask

  task automatic t_release();
    clear_dut();
    run(5, 1, 1'b1);
    run(1, 25, 1'b1);
    check("R6 error 25 holds", lock, 1'b1);
    run(1, 18, 1'b0);
    check("R6 error 18 holds", lock, 1'b1);
    run(1, 26, 1'b1);
    check("R6 error 26 drops", lock, 1'b0);
    run(5, 1, 1'b1);
    run(1, 40, 1'b1);
    check("R6 saturated drops", lock, 1'b0);
  endtask

  task automatic t_dup();
    clear_dut();
    run(5, 1, 1'b1);
    dup_ref();
    check("R7 duplicate drops lock", lock, 1'b0);
    run(3, 1, 1'b1);
    check("R7 pair after duplicate counts", lock, 1'b0);
    run(1, 1, 1'b1);
    check("R7 run completes", lock, 1'b1);
    clear_dut();
    run(4, 1, 1'b1);
    dup_ref();
    run(3, 1, 1'b1);
    check("R7 duplicate clears run", lock, 1'b0);
  endtask

  task automatic t_pd();
    clear_dut();
    run(5, 1, 1'b1);
    @(negedge clk); pwr_dn = 1'b1;
    @(negedge clk);
    check("R8 power-down drops", lock, 1'b0);
    run(6, 1, 1'b1);
    check("R8 pulses ignored", lock, 1'b0);
    pwr_dn = 1'b0;
    // open pair left by a pre-power-down edge must be gone
    @(negedge clk); ref_p = 1'b1;
    @(negedge clk); ref_p = 1'b0; pwr_dn = 1'b1;
    @(negedge clk); pwr_dn = 1'b0;
    run(4, 1, 1'b1);
    check("R8 open pair cleared", lock, 1'b0);
    run(1, 1, 1'b1);
    check("R8 lock after power-up", lock, 1'b1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_loose();
    t_tight();
    t_run_clear();
    t_release();
    t_dup();
    t_pd();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule